// File: doc/BRIEF.md
# Selectable-Ratio Controller Clock Divider

The block derives a controller clock from its input clock. A 3-bit ratio select picks one of eight divide ratios from a non-uniform table that includes 6 and 24. Every ratio of two or more gives a 50% duty output. The block produces two results: a level `div_clk_o` that stands for the divided clock, and a one-cycle pulse `tick_o` that marks each divided period, for logic that uses clock enables. Both are registered in the input clock domain.

A divider-reset input holds the counter at zero. The ratio is taken into use only while that reset is asserted. A select change made while the divider runs is captured for readback but has no effect until the next divider reset. An enable input gates both results to zero. A bypass select replaces the divided level with an external clock. That clock is sampled in the input domain, and the switch is made through registered selects, so it behaves as a glitch-free multiplexer. Software reads back the captured select and enable to confirm that initialisation succeeded, and reads the applied ratio separately.

Top module: `clkdiv_sel`

## Requirements
- R1: Select code s maps to divide ratio 1, 2, 4, 6, 8, 16, 24, 32 for s = 0, 1, 2, 3, 4, 5, 6, 7 respectively. The period of `div_clk_o` and of `tick_o` equals the ratio.
- R2: For every ratio of two or more, `div_clk_o` is low for ratio/2 consecutive cycles and then high for ratio/2 consecutive cycles, with the enable set and bypass clear.
- R3: For a ratio r of two or more, `tick_o` is high for exactly one cycle in every r cycles.
- R4: Let cycle n=0 be the first rising edge at which `div_rst_i` is sampled low. After edge n, `div_clk_o` equals floor(n/(r/2)) mod 2, and `tick_o` is high exactly when (n+1) mod r = 0.
- R5: With ratio 1, `div_clk_o` and `tick_o` are both low after edge 0 and both held high from edge 1 onward while the divider runs.
- R6: A change of `ratio_sel_i` while `div_rst_i` is low leaves the output waveform and `sel_applied_o` unchanged. The new code is applied only when `div_rst_i` is next asserted.
- R7: When `clk_en_i` is 0, `div_clk_o` and `tick_o` are 0 from the second rising edge after the change onward.
- R8: When `bypass_i` is 1, `div_clk_o` equals the `ext_clk_i` value sampled two rising edges earlier, ANDed with the enable, and `tick_o` is 0.
- R9: `sel_rb_o` and `en_rb_o` return `ratio_sel_i` and `clk_en_i` one rising edge after they are written, whatever the state of the divider.
- R10: Under `rst` every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (coprocessor) clock |
| rst | input | 1 | Synchronous active-high reset |
| div_rst_i | input | 1 | Holds the divider at zero; the ratio is applied while high |
| clk_en_i | input | 1 | Output enable; 0 forces both results low |
| bypass_i | input | 1 | 0 selects the divided clock, 1 selects the external clock |
| ext_clk_i | input | 1 | External clock for bypass mode |
| ratio_sel_i | input | 3 | Ratio select code (see R1) |
| div_clk_o | output | 1 | Registered divided or bypassed clock level |
| tick_o | output | 1 | One-cycle pulse per divided period |
| sel_rb_o | output | 3 | Readback of the last written select code |
| en_rb_o | output | 1 | Readback of the enable |
| sel_applied_o | output | 3 | Select code currently in use by the divider |

## Verification
Readbacks are due one edge after the write. Enable and bypass changes reach `div_clk_o` two edges after they are driven, and an external clock sample appears two edges after it is driven. The divided waveform is indexed from the first edge at which the divider reset is seen low. The bench drives inputs on falling edges and samples on the next falling edge. It counts edges from the release and compares each cycle against closed-form functions of that index and the ratio. For enable and bypass checks it waits out the two-edge latency, and it keeps a two-deep history of the driven external levels.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 32;
  localparam int CNT_W     = $clog2(MAX_RATIO / 2);

  // Non-uniform ratio table: 1,2,4,6,8,16,24,32
  function automatic int unsigned ratio_of(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 16;
      3'd6:    return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_capture.sv
module clkdiv_capture
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_i,
  input  logic             bypass_i,
  input  logic             ext_clk_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             en_q,
  output logic             byp_q,
  output logic             ext_q,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      byp_q <= 1'b0;
      ext_q <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= clk_en_i;
      byp_q <= bypass_i;
      ext_q <= ext_clk_i;
      sel_q <= ratio_sel_i;
    end
  end

  // R9: readback follows the written value one edge later
  p_readback_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sel_q == $past(ratio_sel_i)) && (en_q == $past(clk_en_i)));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             div_rst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic [SEL_W-1:0] sel_act,
  output logic             level,
  output logic             tick_c
);
  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             running;
  logic             unity;
  logic [CNT_W-1:0] half_m1;
  int unsigned      ratio;

  always_comb begin
    ratio   = ratio_of(sel_act);
    unity   = (ratio == 1);
    half_m1 = unity ? '0 : CNT_W'(ratio / 2 - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_act <= '0;
      cnt     <= '0;
      phase   <= 1'b0;
      running <= 1'b0;
    end else if (div_rst_i) begin
      sel_act <= ratio_sel_i;
      cnt     <= '0;
      phase   <= 1'b0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      if (!unity) begin
        if (cnt == half_m1) begin
          cnt   <= '0;
          phase <= ~phase;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    level  = unity ? running : phase;
    tick_c = running && (unity || (phase && cnt == half_m1));
  end

  // R6: applied ratio only moves while the divider reset is held
  p_ratio_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(div_rst_i) |-> $stable(sel_act));
  // R4: reset of the divider restarts it from zero
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    div_rst_i |=> (cnt == '0) && !phase);
  // R2: counter never passes the half-period limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= half_m1);
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out (
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  input  logic byp_q,
  input  logic ext_q,
  input  logic level,
  input  logic tick_c,
  output logic div_clk_o,
  output logic tick_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_clk_o <= 1'b0;
      tick_o    <= 1'b0;
    end else begin
      div_clk_o <= en_q && (byp_q ? ext_q : level);
      tick_o    <= en_q && !byp_q && tick_c;
    end
  end

  // R7: disabled output stays low
  p_gate_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !div_clk_o && !tick_o);
  // R8: no pulses while bypassed
  p_bypass_tick_r8: assert property (@(posedge clk) disable iff (rst)
    byp_q |=> !tick_o);
endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             div_rst_i,
  input  logic             clk_en_i,
  input  logic             bypass_i,
  input  logic             ext_clk_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             div_clk_o,
  output logic             tick_o,
  output logic [SEL_W-1:0] sel_rb_o,
  output logic             en_rb_o,
  output logic [SEL_W-1:0] sel_applied_o
);
  logic en_q, byp_q, ext_q, level, tick_c;

  clkdiv_capture u_cap (
    .clk(clk), .rst(rst), .clk_en_i(clk_en_i), .bypass_i(bypass_i),
    .ext_clk_i(ext_clk_i), .ratio_sel_i(ratio_sel_i),
    .en_q(en_q), .byp_q(byp_q), .ext_q(ext_q), .sel_q(sel_rb_o)
  );

  clkdiv_core u_core (
    .clk(clk), .rst(rst), .div_rst_i(div_rst_i), .ratio_sel_i(ratio_sel_i),
    .sel_act(sel_applied_o), .level(level), .tick_c(tick_c)
  );

  clkdiv_out u_out (
    .clk(clk), .rst(rst), .en_q(en_q), .byp_q(byp_q), .ext_q(ext_q),
    .level(level), .tick_c(tick_c), .div_clk_o(div_clk_o), .tick_o(tick_o)
  );

  assign en_rb_o = en_q;

  // R10: everything quiet the cycle after reset
  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> !div_clk_o && !tick_o && sel_rb_o == '0 && !en_rb_o);
endmodule

// File: tb/clkdiv_sel_bench.sv
module clkdiv_sel_bench;
  logic clk = 1'b0;
  logic rst, div_rst, clk_en, bypass, ext_clk;
  logic [2:0] ratio_sel;
  logic div_clk, tick, en_rb;
  logic [2:0] sel_rb, sel_applied;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkdiv_sel u_clkdiv_sel (
    .clk(clk), .rst(rst), .div_rst_i(div_rst), .clk_en_i(clk_en),
    .bypass_i(bypass), .ext_clk_i(ext_clk), .ratio_sel_i(ratio_sel),
    .div_clk_o(div_clk), .tick_o(tick), .sel_rb_o(sel_rb),
    .en_rb_o(en_rb), .sel_applied_o(sel_applied)
  );

  function automatic int ratio_exp(input int s);
    int t[8] = '{1, 2, 4, 6, 8, 16, 24, 32};
    return t[s];
  endfunction

  function automatic int exp_clk(input int r, input int n);
    if (r == 1) return (n >= 1) ? 1 : 0;
    return ((n / (r / 2)) % 2);
  endfunction

  function automatic int exp_tick(input int r, input int n);
    if (r == 1) return (n >= 1) ? 1 : 0;
    return (((n + 1) % r) == 0) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_clk();
    @(posedge clk); @(negedge clk);
  endtask

  // Run divider with code sel; alt is written right after release (R6)
  task automatic run_div(input int sel, input int ncyc, input int alt);
    int r = ratio_exp(sel);
    ratio_sel = 3'(sel); div_rst = 1; clk_en = 1; bypass = 0;
    repeat (3) tick_clk();
    div_rst = 0;
    for (int n = 0; n < ncyc; n++) begin
      tick_clk();
      if (n == 0) ratio_sel = 3'(alt);
      if (r == 1) begin
        check("R5 unity clk", div_clk, exp_clk(r, n));
        check("R5 unity tick", tick, exp_tick(r, n));
      end else begin
        check("R2/R4 clk", div_clk, exp_clk(r, n));
        check("R1/R3 tick", tick, exp_tick(r, n));
      end
    end
    check("R6 applied", sel_applied, sel);
    check("R9 sel readback", sel_rb, alt);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; div_rst = 1; clk_en = 0; bypass = 0; ext_clk = 0; ratio_sel = 0;
    repeat (3) tick_clk();
    // R10 reset state
    check("R10 clk", div_clk, 0);
    check("R10 tick", tick, 0);
    check("R10 sel_rb", sel_rb, 0);
    check("R10 en_rb", en_rb, 0);
    rst = 0;
    tick_clk();

    // directed: every code, R1 R2 R3 R4 R5
    for (int s = 0; s < 8; s++) run_div(s, 3 * ratio_exp(s) + 2, s);

    // R6: change code mid-run, then re-apply through divider reset
    run_div(3, 20, 6);
    ratio_sel = 3'd6; div_rst = 1;
    tick_clk();
    check("R6 new applied", sel_applied, 6);

    // random runs with random late writes
    for (int k = 0; k < 30; k++) begin
      int s = $urandom_range(0, 7);
      int a = $urandom_range(0, 7);
      run_div(s, $urandom_range(2, 3 * ratio_exp(s)) + 1, a);
    end

    // R7: enable off while running
    run_div(2, 5, 2);
    clk_en = 0;
    tick_clk();
    check("R9 en readback", en_rb, 0);
    tick_clk();
    for (int n = 0; n < 12; n++) begin
      check("R7 clk gated", div_clk, 0);
      check("R7 tick gated", tick, 0);
      tick_clk();
    end

    // R8: bypass passes external clock with two edges of delay
    begin
      int h1 = 0, h2 = 0;
      clk_en = 1; bypass = 1; ext_clk = 0;
      repeat (3) tick_clk();
      for (int n = 0; n < 40; n++) begin
        if (n >= 2) begin
          check("R8 bypass clk", div_clk, h2);
          check("R8 bypass tick", tick, 0);
        end
        h2 = h1;
        ext_clk = (n % 3 == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        h1 = int'(ext_clk);
        tick_clk();
      end
    end
    bypass = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule